// File: doc/BRIEF.md
# Accumulator-Stack Zero-Operand Execution Unit

This unit executes one decoded instruction per cycle. Each instruction is an opcode plus a register index. The four arithmetic instructions have no explicit operands. Each one combines the accumulator, as left operand, with the value on top of an internal last-in first-out stack, and writes the result back into the accumulator. The stack top is read, not removed, so the same value stays available to the next instruction.

Three one-operand instructions move data between a small register file, the stack and the accumulator:

- push copies a value onto the stack;
- pop moves the top entry out of the stack;
- load copies a register into the accumulator.

The accumulator can itself be named as the operand of these instructions. This lets a program save the accumulator to the stack and restore it later.

A caller asserts `issue_valid` together with the opcode and the index. One cycle later the unit raises `done` for exactly one cycle. In that same cycle it reports any error through three flags:

- a divide by zero;
- a push onto a full stack;
- a pop, or an arithmetic read, on an empty stack.

An instruction that fails leaves all state unchanged. The accumulator and every register are visible on output ports. The registers start from a parameter value, which acts as the block's read-only operand seed.

Top module: `acc_stack_unit`

## Requirements
- R1: After reset, the following hold: the accumulator is 0, each register i holds the REG_INIT slice [i*16 +: 16], the stack is empty, and done and all error flags are low.
- R2: Opcodes 0, 1, 2 and 3 are ADD, SUB, MUL and DIV. Each computes accumulator op top-of-stack, with the accumulator as left operand, and writes the result to the accumulator. ADD and SUB wrap modulo 2^16, and MUL keeps the low 16 bits of the product.
- R3: An arithmetic instruction does not change the stack. The same top value is used again by a following arithmetic instruction.
- R4: DIV treats both operands as signed two's complement and truncates the quotient toward zero.
- R5: A DIV whose stack top is zero leaves the accumulator unchanged and raises err_div0 in its done cycle.
- R6: Opcode 4 (PUSH) copies the value selected by the index onto the top of the stack.
- R7: Opcode 5 (POP) writes the stack top into the selected destination and removes that entry from the stack.
- R8: Opcode 6 (LOAD) copies the selected register into the accumulator.
- R9: Index values 0 to 7 select a register. Index values 8 to 15 (bit 3 set) select the accumulator, for PUSH, POP and LOAD alike.
- R10: A PUSH while the stack holds 8 entries is ignored and raises err_ovf in its done cycle.
- R11: A POP or an arithmetic instruction on an empty stack is ignored and raises err_unf in its done cycle.
- R12: done is high in exactly the cycle after each accepted instruction, also when instructions are issued back to back. It is low otherwise, and the error flags are low outside done cycles.
- R13: Opcode 7 is a no-operation. It raises done and changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Instruction presented this cycle |
| issue_op | input | 3 | Opcode |
| issue_reg | input | 4 | Operand index; bit 3 selects the accumulator |
| done | output | 1 | Pulses one cycle after an accepted instruction |
| err_div0 | output | 1 | Divide by zero in the current done cycle |
| err_ovf | output | 1 | Push onto a full stack in the current done cycle |
| err_unf | output | 1 | Empty-stack access in the current done cycle |
| acc_o | output | 16 | Accumulator value |
| regs_o | output | 128 | Register file, register i at bits [i*16 +: 16] |

## Verification
The bench issues arithmetic instructions twice against the same stack top. A design that popped on arithmetic would then compute with a stale entry or report underflow.

It divides a negative value by a positive one that does not divide it exactly, which exposes floor division or unsigned division. It also divides by zero to show that the accumulator is kept, and multiplies two values whose product exceeds 16 bits.

The stack is filled to its limit, pushed once more, drained and popped once more. A design that wrapped its pointer would lose or corrupt entries, and that shows up when the popped values are compared with the expected ones. Indices with bit 3 set are used with push, pop and load to catch a design that decoded them as a register.

// File: rtl/acsu_pkg.sv
package acsu_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_MUL  = 3'd2,
      OP_DIV  = 3'd3,
      OP_PUSH = 3'd4,
      OP_POP  = 3'd5,
      OP_LOAD = 3'd6,
      OP_NOP  = 3'd7
   } acsu_op_e;

   function automatic logic acsu_is_arith(input acsu_op_e op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_DIV);
   endfunction

endpackage

// File: rtl/acsu_alu.sv
module acsu_alu
   import acsu_pkg::*;
#(
   parameter int  DATA_W     = 16,
   parameter bit  DIV_SIGNED = 1'b1
) (
   input  acsu_op_e          op,
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   output logic [DATA_W-1:0] result,
   output logic              rhs_zero
);

   logic [DATA_W-1:0] quot;
   logic [DATA_W-1:0] prod;

   assign rhs_zero = (rhs == '0);
   assign prod     = lhs * rhs;

   generate
      if (DIV_SIGNED) begin : g_sdiv
         always_comb begin
            if (rhs_zero) quot = lhs;
            else          quot = DATA_W'($signed(lhs) / $signed(rhs));
         end
      end else begin : g_udiv
         always_comb begin
            if (rhs_zero) quot = lhs;
            else          quot = lhs / rhs;
         end
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_ADD:  result = lhs + rhs;
         OP_SUB:  result = lhs - rhs;
         OP_MUL:  result = prod;
         OP_DIV:  result = quot;
         default: result = lhs;
      endcase
   end

endmodule

// File: rtl/acsu_lifo.sv
module acsu_lifo #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   localparam int PW    = $clog2(DEPTH),
   localparam int LW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] top,
   output logic              empty,
   output logic              full,
   output logic [LW-1:0]     level
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [LW-1:0]     sp_q;
   logic [PW-1:0]     wr_ptr;
   logic [PW-1:0]     rd_ptr;

   assign level  = sp_q;
   assign empty  = (sp_q == '0);
   assign full   = (sp_q == LW'(DEPTH));
   assign wr_ptr = PW'(sp_q);
   assign rd_ptr = PW'(sp_q - 1'b1);
   assign top    = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= '0;
      end else if (push && !full) begin
         sp_q <= sp_q + 1'b1;
      end else if (pop && !empty) begin
         sp_q <= sp_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) mem[wr_ptr] <= din;
   end

   // R7: a granted pop lowers the level by exactly one
   p_pop_lowers_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !empty) |=> (sp_q == $past(sp_q) - 1'b1));

   // R10: the level never passes the depth
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_q <= LW'(DEPTH)));

endmodule

// File: rtl/acsu_regfile.sv
module acsu_regfile #(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 8,
   parameter logic [NUM_REGS*DATA_W-1:0] REG_INIT = '0,
   localparam int RW = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [RW-1:0]              idx,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   output logic [NUM_REGS*DATA_W-1:0] flat
);

   logic [DATA_W-1:0] regs [NUM_REGS];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs[i] <= REG_INIT[i*DATA_W +: DATA_W];
            end else if (we && (idx == RW'(i))) begin
               regs[i] <= wdata;
            end
         end
         assign flat[i*DATA_W +: DATA_W] = regs[i];
      end
   endgenerate

   assign rdata = regs[idx];

endmodule

// File: rtl/acc_stack_unit.sv
module acc_stack_unit
   import acsu_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int NUM_REGS    = 8,
   parameter int STACK_DEPTH = 8,
   parameter bit DIV_SIGNED  = 1'b1,
   parameter logic [NUM_REGS*DATA_W-1:0] REG_INIT = '0,
   localparam int RW = $clog2(NUM_REGS),
   localparam int IW = RW + 1,
   localparam int LW = $clog2(STACK_DEPTH + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       issue_valid,
   input  logic [2:0]                 issue_op,
   input  logic [IW-1:0]              issue_reg,
   output logic                       done,
   output logic                       err_div0,
   output logic                       err_ovf,
   output logic                       err_unf,
   output logic [DATA_W-1:0]          acc_o,
   output logic [NUM_REGS*DATA_W-1:0] regs_o
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if ((NUM_REGS < 2) || ((1 << RW) != NUM_REGS)) begin : g_bad_regs
         $error("NUM_REGS must be a power of two, at least 2");
      end
      if (STACK_DEPTH < 2) begin : g_bad_depth
         $error("STACK_DEPTH must be at least 2");
      end
   endgenerate

   acsu_op_e          op;
   logic              sel_acc;
   logic [RW-1:0]     ridx;
   logic [DATA_W-1:0] acc_q, acc_d;
   logic [DATA_W-1:0] rf_rd, src_val;
   logic              rf_we;
   logic [DATA_W-1:0] stk_top;
   logic              stk_empty, stk_full, stk_push, stk_pop;
   logic [LW-1:0]     stk_level;
   logic [DATA_W-1:0] alu_res;
   logic              alu_dz;
   logic              div0_d, ovf_d, unf_d;

   assign op      = acsu_op_e'(issue_op);
   assign sel_acc = issue_reg[IW-1];
   assign ridx    = issue_reg[RW-1:0];
   assign src_val = sel_acc ? acc_q : rf_rd;

   acsu_regfile #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS),
      .REG_INIT (REG_INIT)
   ) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (rf_we),
      .idx   (ridx),
      .wdata (stk_top),
      .rdata (rf_rd),
      .flat  (regs_o)
   );

   acsu_lifo #(
      .DATA_W (DATA_W),
      .DEPTH  (STACK_DEPTH)
   ) u_stk (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (stk_push),
      .pop   (stk_pop),
      .din   (src_val),
      .top   (stk_top),
      .empty (stk_empty),
      .full  (stk_full),
      .level (stk_level)
   );

   acsu_alu #(
      .DATA_W     (DATA_W),
      .DIV_SIGNED (DIV_SIGNED)
   ) u_alu (
      .op       (op),
      .lhs      (acc_q),
      .rhs      (stk_top),
      .result   (alu_res),
      .rhs_zero (alu_dz)
   );

   always_comb begin
      acc_d    = acc_q;
      stk_push = 1'b0;
      stk_pop  = 1'b0;
      rf_we    = 1'b0;
      div0_d   = 1'b0;
      ovf_d    = 1'b0;
      unf_d    = 1'b0;
      if (issue_valid) begin
         unique case (op)
            OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
               if (stk_empty)                    unf_d  = 1'b1;
               else if ((op == OP_DIV) && alu_dz) div0_d = 1'b1;
               else                              acc_d  = alu_res;
            end
            OP_PUSH: begin
               if (stk_full) ovf_d    = 1'b1;
               else          stk_push = 1'b1;
            end
            OP_POP: begin
               if (stk_empty) begin
                  unf_d = 1'b1;
               end else begin
                  stk_pop = 1'b1;
                  if (sel_acc) acc_d = stk_top;
                  else         rf_we = 1'b1;
               end
            end
            OP_LOAD: acc_d = src_val;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         done     <= 1'b0;
         err_div0 <= 1'b0;
         err_ovf  <= 1'b0;
         err_unf  <= 1'b0;
      end else begin
         acc_q    <= acc_d;
         done     <= issue_valid;
         err_div0 <= div0_d;
         err_ovf  <= ovf_d;
         err_unf  <= unf_d;
      end
   end

   assign acc_o = acc_q;

   // R12: done follows each accepted instruction, and only those
   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |=> done);
   p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |=> !done);
   p_flags_in_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (err_div0 || err_ovf || err_unf) |-> done);
   p_one_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_div0, err_ovf, err_unf}));

   // R3: arithmetic never moves the stack
   p_arith_keeps_stack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && acsu_is_arith(op)) |=> $stable(stk_level));

   // R5: a zero divisor keeps the accumulator
   p_div0_keeps_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_div0 |-> $stable(acc_q));

   // R10: push on a full stack is flagged and dropped
   p_push_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && (op == OP_PUSH) && stk_full) |=> (err_ovf && $stable(stk_level)));

   // R11: empty-stack access is flagged and changes nothing
   p_empty_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && ((op == OP_POP) || acsu_is_arith(op)) && stk_empty)
      |=> (err_unf && $stable(acc_q) && $stable(regs_o)));

endmodule

// File: tb/acc_stack_unit_test.sv
module acc_stack_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [127:0] INIT = {16'h8000, 16'd2, 16'd0, 16'hFFF9,
                                    16'd4, 16'd3, 16'd300, 16'd20};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         issue_valid = 1'b0;
   logic [2:0]   issue_op = 3'd0;
   logic [3:0]   issue_reg = 4'd0;
   logic         done, err_div0, err_ovf, err_unf;
   logic [15:0]  acc_o;
   logic [127:0] regs_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_stack_unit #(.REG_INIT(INIT)) uut (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
      .issue_reg(issue_reg), .done(done), .err_div0(err_div0), .err_ovf(err_ovf),
      .err_unf(err_unf), .acc_o(acc_o), .regs_o(regs_o)
   );

   typedef struct {
      logic [15:0]  acc;
      logic [127:0] regs;
      logic [2:0]   flags;
      string        tag;
   } exp_t;

   exp_t        expq[$];
   logic [15:0] mstk[$];
   logic [15:0] macc;
   logic [15:0] mregs [8];
   int          checks = 0;
   int          fails = 0;
   int          cycles = 0;

   function automatic logic [127:0] pack_regs();
      logic [127:0] v;
      for (int i = 0; i < 8; i++) v[i*16 +: 16] = mregs[i];
      return v;
   endfunction

   task automatic issue(input logic [2:0] op, input logic [3:0] r, input string tag);
      exp_t        e;
      logic [15:0] val;
      logic [15:0] t;
      logic [2:0]  fl;
      logic signed [15:0] sa, sb;
      fl  = 3'b000;
      val = r[3] ? macc : mregs[r[2:0]];
      if (op <= 3'd3) begin
         if (mstk.size() == 0) begin
            fl[0] = 1'b1;
         end else begin
            t = mstk[$];
            case (op)
               3'd0: macc = macc + t;
               3'd1: macc = macc - t;
               3'd2: macc = macc * t;
               default: begin
                  if (t == 16'd0) fl[2] = 1'b1;
                  else begin
                     sa = macc; sb = t; macc = sa / sb;
                  end
               end
            endcase
         end
      end else if (op == 3'd4) begin
         if (mstk.size() == 8) fl[1] = 1'b1;
         else mstk.push_back(val);
      end else if (op == 3'd5) begin
         if (mstk.size() == 0) fl[0] = 1'b1;
         else begin
            t = mstk.pop_back();
            if (r[3]) macc = t;
            else mregs[r[2:0]] = t;
         end
      end else if (op == 3'd6) begin
         macc = val;
      end
      e.acc = macc; e.regs = pack_regs(); e.flags = fl; e.tag = tag;
      expq.push_back(e);
      issue_valid = 1'b1; issue_op = op; issue_reg = r;
      @(negedge clk);
   endtask

   // monitor: compare each done cycle with the oldest expectation
   always @(negedge clk) begin
      if (rst_n && done) begin
         checks++;
         if (expq.size() == 0) begin
            fails++;
            $display("FAIL R12: done with no instruction pending (act done=1, exp 0)");
         end else begin
            exp_t e;
            e = expq.pop_front();
            if (acc_o !== e.acc || regs_o !== e.regs ||
                {err_div0, err_ovf, err_unf} !== e.flags) begin
               fails++;
               $display("FAIL %s: acc=%h regs=%h flags=%b, expected acc=%h regs=%h flags=%b",
                        e.tag, acc_o, regs_o, {err_div0, err_ovf, err_unf},
                        e.acc, e.regs, e.flags);
            end
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         fails++; checks++;
         $display("FAIL watchdog: run did not finish (act cycles=%0d, exp < 20000)", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      macc = 16'd0;
      for (int i = 0; i < 8; i++) mregs[i] = INIT[i*16 +: 16];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      checks++;
      if (acc_o !== 16'd0 || regs_o !== INIT || done !== 1'b0 ||
          {err_div0, err_ovf, err_unf} !== 3'b000) begin
         fails++;
         $display("FAIL R1: acc=%h regs=%h done=%b flags=%b, expected acc=0 regs=%h done=0 flags=000",
                  acc_o, regs_o, done, {err_div0, err_ovf, err_unf}, INIT);
      end
      issue(3'd0, 4'd0, "R11");   // ADD on empty stack
      issue(3'd5, 4'd1, "R11");   // POP on empty stack
      issue(3'd6, 4'd2, "R8");    // acc = 3
      issue(3'd4, 4'd3, "R6");    // push 4
      issue(3'd2, 4'd0, "R2");    // 3*4 = 12
      issue(3'd0, 4'd0, "R3");    // 12+4 = 16, same top reused
      issue(3'd4, 4'd0, "R6");    // push 20
      issue(3'd1, 4'd0, "R2");    // 16-20 = -4
      issue(3'd6, 4'd1, "R8");    // acc = 300
      issue(3'd4, 4'd1, "R6");    // push 300
      issue(3'd2, 4'd0, "R2");    // 300*300 low bits = 0x5F90
      issue(3'd6, 4'd4, "R8");    // acc = -7
      issue(3'd4, 4'd6, "R6");    // push 2
      issue(3'd3, 4'd0, "R4");    // -7/2 = -3
      issue(3'd3, 4'd0, "R4");    // -3/2 = -1
      issue(3'd4, 4'd5, "R6");    // push 0
      issue(3'd3, 4'd0, "R5");    // divide by zero
      issue(3'd7, 4'd0, "R13");   // no-op
      issue(3'd5, 4'd1, "R7");    // r1 = 0
      issue(3'd5, 4'd8, "R9");    // acc = 2 via accumulator index
      issue(3'd6, 4'd7, "R8");    // acc = 0x8000
      issue(3'd4, 4'd12, "R9");   // push accumulator
      issue(3'd6, 4'd0, "R8");    // acc = 20
      issue(3'd6, 4'd9, "R9");    // load from accumulator: unchanged
      issue(3'd5, 4'd3, "R7");    // r3 = 0x8000
      while (mstk.size() < 8) issue(3'd4, 4'd0, "R6");
      issue(3'd4, 4'd2, "R10");   // push on full
      issue(3'd4, 4'd8, "R10");
      for (int k = 0; k < 8; k++) issue(3'd5, 4'(k), "R7");
      issue(3'd5, 4'd2, "R11");   // pop on empty
      issue(3'd3, 4'd0, "R11");   // divide on empty
      issue_valid = 1'b0;
      repeat (3) @(negedge clk);
      // R12: no done while idle, and every expectation consumed
      checks++;
      if (done !== 1'b0 || expq.size() != 0) begin
         fails++;
         $display("FAIL R12: done=%b pending=%0d, expected done=0 pending=0", done, expq.size());
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule